// File: doc/BRIEF.md
# SECDED-Protected Single-Port RAM with Fault Injection

This block wraps a single-port synchronous RAM so that every stored word carries single-error-correct, double-error-detect check bits. On each write the check bits are computed from the write data and stored beside it, whether or not checking is enabled. A later read returns the word one cycle after the request. When checking is on, a single flipped bit is repaired before it reaches the output, and a two-bit fault is flagged as uncorrectable.

A control interface holds a global enable for checking and a one-shot fault-injection setting. Software arms a single-bit or double-bit fault. The fault then lands in the data half of the next word written. After that write the setting returns to idle by itself, so one fault can be placed at a chosen address and read back to test the consumer's error path. An event output goes high whenever a read reports an error. External logic watches this output to notice repeated faults and decide whether to reset the consumer.

Top module: `ecc_ram`

## Requirements
- R1: A read request (`rd_en_i` high with `wr_en_i` low) raises `rd_valid_o` on the following cycle with the addressed word on `rd_data_o`; `rd_valid_o` is low in every other cycle.
- R2: With checking enabled, reading a word written without injection returns the written data with `corr_err_o` and `uncorr_err_o` both low.
- R3: When `inj_set_i` is high, the injection setting loads from `inj_mode_i`, where 2'b00 means none, 2'b01 means single-bit and 2'b10 means double-bit; 2'b11 loads none. The current setting is shown on `inj_pend_o` with the same encoding.
- R4: An armed setting affects only the next write. Single-bit injection inverts stored data bit 0, and double-bit injection inverts stored data bits 0 and 1. After that write `inj_pend_o` returns to 2'b00, and later writes are stored unaltered.
- R5: With checking enabled, a word with one flipped bit is returned corrected, and `corr_err_o` is high for exactly the one cycle in which `rd_valid_o` is high.
- R6: With checking enabled, a word with two flipped bits raises `uncorr_err_o` with `rd_valid_o`, keeps `corr_err_o` low, and returns the stored data uncorrected.
- R7: A read issued while `ecc_en_i` is low returns the raw stored data, and both error flags stay low.
- R8: Check bits are stored on every write, including writes made while `ecc_en_i` is low, so a later read with checking enabled detects or corrects a fault injected during such a write.
- R9: `err_evt_o` is high exactly in the cycles where `corr_err_o` or `uncorr_err_o` is high.
- R10: The error flags are high only together with `rd_valid_o`. A cycle with both `wr_en_i` and `rd_en_i` high performs only the write and produces no read response.
- R11: While reset is held, and just after it is released, `rd_valid_o`, both error flags, `err_evt_o` and `inj_pend_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ecc_en_i | input | 1 | Enables checking and error reporting on reads |
| inj_set_i | input | 1 | Loads the injection setting from inj_mode_i |
| inj_mode_i | input | 2 | Injection request: 00 none, 01 single, 10 double |
| inj_pend_o | output | 2 | Injection setting currently armed |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe, ignored when wr_en_i is high |
| addr_i | input | ADDR_W (6) | Word address |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_data_o | output | DATA_W (32) | Read data, corrected when checking is enabled |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| corr_err_o | output | 1 | Corrected single-bit error on this read |
| uncorr_err_o | output | 1 | Uncorrectable error on this read |
| err_evt_o | output | 1 | Error event for external monitoring |

## Verification
The assertions assume that addresses are read only after they have been written and that `inj_mode_i` is meaningful only while `inj_set_i` is high. They also assume that the only faults in the array are the ones the injection path places there. The bench initialises every address before it issues any random read, and it tracks for each address which injection kind the last write carried. Arms are issued with all four mode codes, including the reserved one. Enables, writes and reads are driven at random from a fixed seed, so both enabled and disabled reads fall on clean, single-fault and double-fault words.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

  typedef enum logic [1:0] {
    INJ_NONE   = 2'b00,
    INJ_SINGLE = 2'b01,
    INJ_DOUBLE = 2'b10
  } inj_mode_e;

  // Hamming parity count: smallest p with 2^p >= data + p + 1
  function automatic int par_bits(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PAR_W = par_bits(DATA_W),
  localparam int CHK_W = PAR_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  localparam int CW_N = DATA_W + PAR_W;

  logic [PAR_W-1:0] par;

  // data bits occupy the non-power-of-two positions 3,5,6,7,9,...
  always_comb begin
    int j;
    par = '0;
    j = 0;
    for (int pos = 1; pos <= CW_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int i = 0; i < PAR_W; i++) begin
          if (((pos >> i) & 1) == 1) par[i] = par[i] ^ data_i[j];
        end
        j++;
      end
    end
    chk_o = {^{data_i, par}, par};
  end

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PAR_W = par_bits(DATA_W),
  localparam int CHK_W = PAR_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sgl_o,
  output logic              dbl_o
);
  localparam int CW_N = DATA_W + PAR_W;

  logic [CHK_W-1:0] chk_re;
  logic [PAR_W-1:0] syn;
  logic             odd;
  logic             in_range;

  ecc_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i(data_i),
    .chk_o (chk_re)
  );

  assign syn      = chk_re[PAR_W-1:0] ^ chk_i[PAR_W-1:0];
  assign odd      = ^{data_i, chk_i};
  assign in_range = int'(syn) <= CW_N;
  assign sgl_o    = odd && in_range;
  assign dbl_o    = (!odd && syn != '0) || (odd && !in_range);

  always_comb begin
    int j;
    data_o = data_i;
    j = 0;
    for (int pos = 1; pos <= CW_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (sgl_o && PAR_W'(pos) == syn) data_o[j] = ~data_i[j];
        j++;
      end
    end
  end

endmodule

// File: rtl/ecc_inj.sv
module ecc_inj
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [1:0]        mode_i,
  input  logic              we_i,
  output logic [1:0]        pend_o,
  output logic [DATA_W-1:0] mask_o
);
  inj_mode_e pend_q, mode_n;

  always_comb begin
    unique case (mode_i)
      2'b01:   mode_n = INJ_SINGLE;
      2'b10:   mode_n = INJ_DOUBLE;
      default: mode_n = INJ_NONE;
    endcase
  end

  // arming wins over the self-clear of a concurrent write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= INJ_NONE;
    else if (set_i) pend_q <= mode_n;
    else if (we_i)  pend_q <= INJ_NONE;
  end

  always_comb begin
    mask_o = '0;
    if (we_i) begin
      unique case (pend_q)
        INJ_SINGLE: mask_o[0]   = 1'b1;
        INJ_DOUBLE: mask_o[1:0] = 2'b11;
        default:    mask_o      = '0;
      endcase
    end
  end

  assign pend_o = pend_q;

  assert_inj_load_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && mode_i == 2'b01) |=> pend_o == 2'b01);
  assert_inj_load_double_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && mode_i == 2'b10) |=> pend_o == 2'b10);
  assert_inj_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && mode_i == 2'b11) |=> pend_o == 2'b00);
  assert_inj_self_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !set_i) |=> pend_o == 2'b00);
  assert_inj_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !set_i) |=> $stable(pend_o));

endmodule

// File: rtl/ecc_mem.sv
module ecc_mem #(
  parameter int WORD_W = 39,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end

endmodule

// File: rtl/ecc_ram.sv
module ecc_ram
  import ecc_ram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ecc_en_i,
  input  logic              inj_set_i,
  input  logic [1:0]        inj_mode_i,
  output logic [1:0]        inj_pend_o,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              corr_err_o,
  output logic              uncorr_err_o,
  output logic              err_evt_o
);
  localparam int PAR_W  = par_bits(DATA_W);
  localparam int CHK_W  = PAR_W + 1;
  localparam int WORD_W = DATA_W + CHK_W;

  logic              rd_go;
  logic [CHK_W-1:0]  wr_chk;
  logic [DATA_W-1:0] inj_mask;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [DATA_W-1:0] fix_data;
  logic              dec_sgl, dec_dbl;
  logic              rvalid_q, en_q;

  assign rd_go = rd_en_i && !wr_en_i;

  ecc_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i(wr_data_i),
    .chk_o (wr_chk)
  );

  ecc_inj #(.DATA_W(DATA_W)) u_inj (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (inj_set_i),
    .mode_i(inj_mode_i),
    .we_i  (wr_en_i),
    .pend_o(inj_pend_o),
    .mask_o(inj_mask)
  );

  // check bits cover the clean data; the fault lands after encoding
  assign wr_word = {wr_chk, wr_data_i ^ inj_mask};

  ecc_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .re_i   (rd_go),
    .addr_i (addr_i),
    .wdata_i(wr_word),
    .rdata_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
      if (rd_go) en_q <= ecc_en_i;
    end
  end

  ecc_dec #(.DATA_W(DATA_W)) u_dec (
    .data_i(rd_word[DATA_W-1:0]),
    .chk_i (rd_word[WORD_W-1:DATA_W]),
    .data_o(fix_data),
    .sgl_o (dec_sgl),
    .dbl_o (dec_dbl)
  );

  assign rd_data_o    = (en_q && !dec_dbl) ? fix_data : rd_word[DATA_W-1:0];
  assign rd_valid_o   = rvalid_q;
  assign corr_err_o   = rvalid_q && en_q && dec_sgl;
  assign uncorr_err_o = rvalid_q && en_q && dec_dbl;
  assign err_evt_o    = corr_err_o || uncorr_err_o;

  assert_rd_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> rd_valid_o);
  assert_no_spurious_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && !wr_en_i) |=> !rd_valid_o);
  assert_write_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i) |=> !rd_valid_o);
  assert_flags_need_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_err_o || uncorr_err_o) |-> rd_valid_o);
  assert_flags_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_err_o && uncorr_err_o));
  assert_disabled_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && !ecc_en_i) |=> (!corr_err_o && !uncorr_err_o));
  assert_evt_tracks_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_o == (corr_err_o || uncorr_err_o));
  assert_corr_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_err_o && !(rd_en_i && !wr_en_i)) |=> !corr_err_o);

endmodule

// File: tb/tb_ecc_ram.sv
module tb_ecc_ram;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ecc_en = 1'b0;
  logic              inj_set = 1'b0;
  logic [1:0]        inj_mode = 2'b00;
  logic [1:0]        inj_pend;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid, corr_err, uncorr_err, err_evt;

  int checks = 0;
  int fails  = 0;

  // model: last written data, stored (faulted) data, fault kind per address
  logic [DATA_W-1:0] m_orig [DEPTH];
  logic [DATA_W-1:0] m_stor [DEPTH];
  logic [1:0]        m_kind [DEPTH];
  logic [1:0]        m_pend = 2'b00;

  always #5 clk = ~clk;

  ecc_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ecc_en_i(ecc_en),
    .inj_set_i(inj_set), .inj_mode_i(inj_mode), .inj_pend_o(inj_pend),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .corr_err_o(corr_err),
    .uncorr_err_o(uncorr_err), .err_evt_o(err_evt)
  );

  function automatic logic [DATA_W-1:0] fault_mask(logic [1:0] k);
    if (k == 2'b01) return 32'h1;
    if (k == 2'b10) return 32'h3;
    return '0;
  endfunction

  function automatic logic [1:0] norm_mode(logic [1:0] m);
    return (m == 2'b11) ? 2'b00 : m;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(logic [1:0] m);
    @(negedge clk);
    inj_set = 1'b1; inj_mode = m;
    @(negedge clk);
    inj_set = 1'b0; inj_mode = 2'b00;
    m_pend = norm_mode(m);
  endtask

  task automatic write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic also_rd);
    @(negedge clk);
    wr_en = 1'b1; rd_en = also_rd; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    m_orig[a] = d;
    m_kind[a] = m_pend;
    m_stor[a] = d ^ fault_mask(m_pend);
    m_pend = 2'b00;
  endtask

  task automatic read_chk(logic [ADDR_W-1:0] a, logic en, string req);
    logic [DATA_W-1:0] exp_d;
    logic exp_ce, exp_ue;
    @(negedge clk);
    rd_en = 1'b1; addr = a; ecc_en = en;
    @(negedge clk);
    rd_en = 1'b0;
    exp_ce = en && m_kind[a] == 2'b01;
    exp_ue = en && m_kind[a] == 2'b10;
    exp_d  = (en && m_kind[a] != 2'b10) ? m_orig[a] : m_stor[a];
    check({req, " valid"}, 64'(rd_valid), 64'd1);
    check({req, " data"}, 64'(rd_data), 64'(exp_d));
    check({req, " ce"}, 64'(corr_err), 64'(exp_ce));
    check({req, " ue"}, 64'(uncorr_err), 64'(exp_ue));
    check({req, " R9 evt"}, 64'(err_evt), 64'(exp_ce || exp_ue));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1badc0de;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R11 reset values
    check("R11 valid", 64'(rd_valid), 64'd0);
    check("R11 flags", 64'({corr_err, uncorr_err, err_evt}), 64'd0);
    check("R11 pend", 64'(inj_pend), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 pend after release", 64'(inj_pend), 64'd0);
    check("R11 valid after release", 64'(rd_valid), 64'd0);

    for (int a = 0; a < DEPTH; a++) write(ADDR_W'(a), $urandom(), 1'b0);

    // R1 R2 clean read
    read_chk(6'd5, 1'b1, "R1 R2 clean");
    @(negedge clk);
    check("R1 valid drops", 64'(rd_valid), 64'd0);

    // R3 encodings
    arm(2'b01); check("R3 single", 64'(inj_pend), 64'd1);
    arm(2'b11); check("R3 reserved", 64'(inj_pend), 64'd0);
    arm(2'b10); check("R3 double", 64'(inj_pend), 64'd2);

    // R4 R6 double fault, pending clears
    write(6'd10, 32'hdead_beef, 1'b0);
    check("R4 pend cleared", 64'(inj_pend), 64'd0);
    read_chk(6'd10, 1'b0, "R4 R7 raw double");
    check("R4 bits 0,1 flipped", 64'(rd_data), 64'hdead_beec);
    read_chk(6'd10, 1'b1, "R6 double");

    // R4 R5 single fault; next write clean
    arm(2'b01);
    write(6'd11, 32'h1234_5670, 1'b0);
    write(6'd12, 32'h0f0f_0f0f, 1'b0);
    read_chk(6'd11, 1'b0, "R4 raw single");
    check("R4 bit 0 flipped", 64'(rd_data), 64'h1234_5671);
    read_chk(6'd11, 1'b1, "R5 single");
    @(negedge clk);
    check("R5 ce one cycle", 64'(corr_err), 64'd0);
    read_chk(6'd12, 1'b1, "R4 later write clean");

    // R8 check bits stored while disabled
    ecc_en = 1'b0;
    arm(2'b01);
    write(6'd20, 32'hcafe_f00d, 1'b0);
    read_chk(6'd20, 1'b1, "R8 single while disabled");
    arm(2'b10);
    write(6'd21, 32'h5555_aaaa, 1'b0);
    read_chk(6'd21, 1'b1, "R8 double while disabled");

    // R10 write wins over same-cycle read
    write(6'd30, 32'h0bad_f00d, 1'b1);
    check("R10 no read response", 64'(rd_valid), 64'd0);
    check("R10 no flags", 64'({corr_err, uncorr_err}), 64'd0);
    read_chk(6'd30, 1'b1, "R10 write landed");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2) arm(2'($urandom_range(0, 3)));
      else if (op < 5) begin
        ecc_en = ($urandom_range(0, 3) != 0);
        write(ADDR_W'($urandom_range(0, DEPTH - 1)), $urandom(), 1'b0);
      end else
        read_chk(ADDR_W'($urandom_range(0, DEPTH - 1)),
                 ($urandom_range(0, 4) != 0), "R2 R5 R6 R7 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule